// File: doc/BRIEF.md
# Stereo Codec Serial Port Master

This block drives a stereo audio converter over a three-wire serial link. It runs from one master clock and makes two clocks for the converter. The bit clock is the master clock divided by four. The frame clock is the master clock divided by 256. Each frame clock period holds one stereo frame, made of two channel halves of 32 bit slots each. The left half comes first, while the frame clock is low.

Samples are 20 bits wide and sit at the front of each half, most significant bit first, with no delay slot after the frame clock edge. Playback samples arrive as a left/right pair on a parallel valid/ready port, which accepts one pair per frame. When no pair is offered, the last accepted pair is sent again. Serial input data is shifted into one register per channel. Once the right channel has its 20th bit, the pair is presented on parallel outputs with a one-cycle strobe.

Top module: `audio_serial_master`

## Requirements
- R1: While `rst` is high, then from the master clock edge after it is seen, `bclk`, `lrck`, `sdOut` and `rxValid` are all low.
- R2: After reset is released, `bclk` has a period of 4 master cycles. It is high for the first two cycles of each bit slot and low for the last two. Slot 0 of the first frame starts on the first master edge after release.
- R3: `lrck` is low for 128 master cycles (left half) and then high for 128 (right half). It changes only in the cycle where `bclk` rises.
- R4: In slot k (0..31) of a half, `sdOut` carries bit 19-k of that channel's sample when k < 20, and 0 when k >= 20. It changes only when `bclk` rises.
- R5: `txReady` is high for exactly one master cycle per frame: the last cycle of each frame, and also the idle cycle between reset release and the first frame. A pair offered with `txValid` in that cycle is sent in the frame that follows.
- R6: If no pair is accepted for a frame, the previously accepted pair is sent again. After reset the held pair is all zeros.
- R7: `sdIn` is sampled at the end of each slot, on the master edge at which `bclk` rises again. Slots 0..19 are shifted in MSB first. Slots 20..31 have no effect on the captured sample.
- R8: `rxValid` pulses for one cycle per frame, in cycle 208 of the frame (cycle 0 being the first). `rxLeft`/`rxRight` then hold that frame's captured pair and stay unchanged until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| txValid | input | 1 | Playback pair offered |
| txReady | output | 1 | Playback pair accepted this cycle when txValid is high |
| txLeft | input | 20 | Left playback sample |
| txRight | input | 20 | Right playback sample |
| bclk | output | 1 | Bit clock to the converter |
| lrck | output | 1 | Frame clock; low for left, high for right |
| sdOut | output | 1 | Serial playback data |
| sdIn | input | 1 | Serial capture data from the converter |
| rxValid | output | 1 | One-cycle strobe, captured pair is new |
| rxLeft | output | 20 | Captured left sample |
| rxRight | output | 20 | Captured right sample |

## Verification
Outputs are due at fixed frame positions, counted from the first master edge after reset release. Slot k's `sdOut` bit appears in cycle 4k of its half, `txReady` is high in cycle 255, and `rxValid` is high in cycle 208, one register after the final right-channel capture edge at cycle 207. The bench keeps its own cycle counter, derives frame, half, slot and phase from it arithmetically, and compares every output once per cycle at the falling master edge, when all registers have settled. Its converter model drives `sdIn` at falling `bclk` and fills the padding slots with a nonzero pattern. Capture patterns, playback patterns, skipped frames and a mid-frame reset are swept over 16 frames.

// File: rtl/aserPkg.sv
package aserPkg;
  localparam int SAMPLE_W   = 20;
  localparam int SLOT_W     = 32;
  localparam int BCLK_DIV   = 4;
  localparam int PHASE_BITS = $clog2(BCLK_DIV);
  localparam int SLOT_BITS  = $clog2(SLOT_W);
  localparam int CNT_BITS   = PHASE_BITS + SLOT_BITS + 1;
  localparam int FRAME_LEN  = 2 * SLOT_W * BCLK_DIV;

  typedef struct packed {
    logic                 frameLoad;  // next edge starts a frame
    logic                 slotStart;  // next edge starts a bit slot
    logic                 sendRight;  // slot starting belongs to right half
    logic [SLOT_BITS-1:0] sendSlot;   // index of slot starting
    logic                 capture;    // this edge ends a data slot
    logic                 capRight;   // captured bit is right channel
    logic                 pairDone;   // this edge ends last right data slot
  } aserStrobes_t;
endpackage

// File: rtl/aserCtrl.sv
module aserCtrl
  import aserPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  output logic         bclk,
  output logic         lrck,
  output logic         txReady,
  output aserStrobes_t strb
);
  localparam logic [SLOT_BITS:0] DATA_SLOTS = (SLOT_BITS + 1)'(SAMPLE_W);

  logic [CNT_BITS-1:0]  cnt;
  logic [CNT_BITS-1:0]  cntNext;
  logic                 running;
  logic [SLOT_BITS-1:0] curSlot;
  logic                 lastPhase;
  logic                 dataSlot;

  // cnt is the frame position of the outputs now on the pins
  assign cntNext = running ? cnt + 1'b1 : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else begin
      cnt     <= cntNext;
      running <= 1'b1;
    end
  end

  assign curSlot   = cnt[PHASE_BITS +: SLOT_BITS];
  assign lastPhase = (cnt[PHASE_BITS-1:0] == '1);
  assign dataSlot  = ({1'b0, curSlot} < DATA_SLOTS);

  assign bclk    = running & ~cnt[PHASE_BITS-1];
  assign lrck    = running & cnt[CNT_BITS-1];
  assign txReady = ~rst & (cntNext == '0);

  always_comb begin
    strb.frameLoad = txReady;
    strb.slotStart = (cntNext[PHASE_BITS-1:0] == '0);
    strb.sendRight = cntNext[CNT_BITS-1];
    strb.sendSlot  = cntNext[PHASE_BITS +: SLOT_BITS];
    strb.capture   = running & lastPhase & dataSlot;
    strb.capRight  = cnt[CNT_BITS-1];
    strb.pairDone  = running & lastPhase & cnt[CNT_BITS-1] &
                     ({1'b0, curSlot} == DATA_SLOTS - 1'b1);
  end
endmodule

// File: rtl/aserData.sv
module aserData
  import aserPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  aserStrobes_t        strb,
  input  logic                txValid,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  input  logic                sdIn,
  output logic                sdOut,
  output logic                rxValid,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight
);
  logic                accept;
  logic [SAMPLE_W-1:0] holdL, holdR;
  logic [SAMPLE_W-1:0] srcL, srcR, chan;
  logic [SLOT_W-1:0]   slotBits;
  logic [SAMPLE_W-1:0] shL, shR;

  assign accept = strb.frameLoad & txValid;
  assign srcL   = accept ? txLeft  : holdL;
  assign srcR   = accept ? txRight : holdR;
  assign chan   = strb.sendRight ? srcR : srcL;

  // slot-ordered view of the channel word, zero padded past the sample
  for (genvar i = 0; i < SLOT_W; i++) begin : gSlot
    if (i < SAMPLE_W) begin : gData
      assign slotBits[i] = chan[SAMPLE_W-1-i];
    end else begin : gPad
      assign slotBits[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdL <= '0;
      holdR <= '0;
      sdOut <= 1'b0;
    end else begin
      if (accept) begin
        holdL <= txLeft;
        holdR <= txRight;
      end
      if (strb.slotStart) sdOut <= slotBits[strb.sendSlot];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shL     <= '0;
      shR     <= '0;
      rxLeft  <= '0;
      rxRight <= '0;
      rxValid <= 1'b0;
    end else begin
      if (strb.capture) begin
        if (strb.capRight) shR <= {shR[SAMPLE_W-2:0], sdIn};
        else               shL <= {shL[SAMPLE_W-2:0], sdIn};
      end
      if (strb.pairDone) begin
        rxLeft  <= shL;
        rxRight <= {shR[SAMPLE_W-2:0], sdIn};
      end
      rxValid <= strb.pairDone;
    end
  end
endmodule

// File: rtl/audio_serial_master.sv
module audio_serial_master
  import aserPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                txValid,
  output logic                txReady,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                bclk,
  output logic                lrck,
  output logic                sdOut,
  input  logic                sdIn,
  output logic                rxValid,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight
);
  aserStrobes_t strb;

  aserCtrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .bclk    (bclk),
    .lrck    (lrck),
    .txReady (txReady),
    .strb    (strb)
  );

  aserData uData (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .txValid (txValid),
    .txLeft  (txLeft),
    .txRight (txRight),
    .sdIn    (sdIn),
    .sdOut   (sdOut),
    .rxValid (rxValid),
    .rxLeft  (rxLeft),
    .rxRight (rxRight)
  );
endmodule

// File: rtl/aserChecker.sv
module aserChecker
  import aserPkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                bclk,
  input logic                lrck,
  input logic                sdOut,
  input logic                txReady,
  input logic                rxValid,
  input logic [SAMPLE_W-1:0] rxLeft,
  input logic [SAMPLE_W-1:0] rxRight
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!bclk && !lrck && !sdOut && !rxValid));

  assert_bclk_high_two_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk) |=> bclk);

  assert_bclk_low_two_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(bclk) |=> !bclk);

  assert_lrck_on_bclk_rise_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck) |-> $rose(bclk));

  assert_sdout_on_bclk_rise_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdOut) |-> $rose(bclk));

  assert_ready_single_R5: assert property (@(posedge clk) disable iff (rst)
    txReady |=> !txReady);

  assert_ready_bclk_low_R5: assert property (@(posedge clk) disable iff (rst)
    txReady |-> !bclk);

  assert_rxvalid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rxValid |-> ($stable(rxLeft) && $stable(rxRight)));
endmodule

bind audio_serial_master aserChecker uChk (
  .clk     (clk),
  .rst     (rst),
  .bclk    (bclk),
  .lrck    (lrck),
  .sdOut   (sdOut),
  .txReady (txReady),
  .rxValid (rxValid),
  .rxLeft  (rxLeft),
  .rxRight (rxRight)
);

// File: tb/sim_audio_serial_master.sv
module sim_audio_serial_master;
  import aserPkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SW   = SAMPLE_W;
  localparam int HALF = SLOT_W * BCLK_DIV;
  localparam int FR   = 2 * HALF;
  localparam int RX_POS = HALF + SW * BCLK_DIV;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          txValid = 1'b0;
  logic [SW-1:0] txLeft = '0;
  logic [SW-1:0] txRight = '0;
  logic          sdIn = 1'b0;
  logic          txReady, bclk, lrck, sdOut, rxValid;
  logic [SW-1:0] rxLeft, rxRight;

  int checks = 0;
  int errors = 0;
  int tcnt = -2;
  bit done = 1'b0;
  logic [SW-1:0] expL = '0;
  logic [SW-1:0] expR = '0;
  logic [SW-1:0] word;
  int fr, pos, half, slot, ph;

  audio_serial_master u0 (
    .clk(clk), .rst(rst), .txValid(txValid), .txReady(txReady),
    .txLeft(txLeft), .txRight(txRight), .bclk(bclk), .lrck(lrck),
    .sdOut(sdOut), .sdIn(sdIn), .rxValid(rxValid),
    .rxLeft(rxLeft), .rxRight(rxRight)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [SW-1:0] pat(int f, int ch);
    case (f % 8)
      0: return ch ? {SW{1'b1}} : '0;
      1: return ch ? SW'(1) << (SW-1) : SW'(1);
      2: return ch ? {(SW/2){2'b10}} : {(SW/2){2'b01}};
      default: return SW'(f * 32'h3A5C7 + ch * 32'h1F3 + 32'h9);
    endcase
  endfunction

  function automatic logic [SW-1:0] rxPat(int f, int ch);
    return pat(f + 3, 1 - ch) ^ SW'(32'h5A3C1);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at t=%0d", req, act, exp, tcnt);
    end
  endtask

  always @(posedge clk) tcnt <= rst ? -1 : tcnt + 1;

  // converter model and per-cycle checker, away from the active edge
  always @(negedge clk) begin
    if (tcnt == -1 && rst) begin
      check(!bclk && !lrck && !sdOut && !rxValid, "R1 reset outputs",
            {bclk, lrck, sdOut, rxValid}, 0);
      expL = '0;
      expR = '0;
    end else if (tcnt == -1) begin
      check(txReady == 1'b1, "R5 ready before first frame", txReady, 1);
      check(bclk == 1'b0, "R2 bclk idle", bclk, 0);
    end else if (tcnt >= 0) begin
      fr   = tcnt / FR;
      pos  = tcnt % FR;
      half = pos / HALF;
      slot = (pos % HALF) / BCLK_DIV;
      ph   = pos % BCLK_DIV;
      check(bclk == (ph < BCLK_DIV/2), "R2 bclk", bclk, (ph < BCLK_DIV/2));
      check(lrck == half[0], "R3 lrck", lrck, half);
      word = half ? expR : expL;
      check(sdOut == ((slot < SW) ? word[SW-1-slot] : 1'b0), "R4 sdOut",
            sdOut, (slot < SW) ? word[SW-1-slot] : 1'b0);
      check(txReady == (pos == FR-1 && !rst), "R5 txReady", txReady, (pos == FR-1 && !rst));
      check(rxValid == (pos == RX_POS), "R8 rxValid timing", rxValid, (pos == RX_POS));
      if (rxValid) begin
        check(rxLeft == rxPat(fr, 0), "R7 rxLeft", rxLeft, rxPat(fr, 0));
        check(rxRight == rxPat(fr, 1), "R7 rxRight", rxRight, rxPat(fr, 1));
      end
      if (ph == BCLK_DIV/2) begin
        word = rxPat(fr, half);
        // padding slots carry a nonzero pattern that must be ignored (R7)
        sdIn = (slot < SW) ? word[SW-1-slot] : ~slot[0];
      end
    end
    if (txReady && txValid) begin
      expL = txLeft;
      expR = txRight;
    end
  end

  task automatic runFrames(int n, bit zeroFirst);
    for (int f = 0; f < n; f++) begin
      @(posedge clk); #1;
      while (!txReady) begin
        @(posedge clk); #1;
      end
      // frames with f%4==2 offer nothing: repeat expected (R6)
      if (!(zeroFirst && f == 0) && (f % 4 != 2)) begin
        txValid = 1'b1;
        txLeft  = pat(f, 0);
        txRight = pat(f, 1);
      end
      @(posedge clk); #1;
      txValid = 1'b0;
      txLeft  = ~pat(f, 1);
      txRight = ~pat(f, 0);
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    runFrames(10, 1'b0);
    repeat (300) @(posedge clk);
    #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    runFrames(6, 1'b1);
    repeat (FR + 20) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule